// File: doc/BRIEF.md
# Short-Address DMA Channel

This block is one direct memory access channel that moves single bytes or words between a memory-side location and a peripheral-side location. Each accepted activation request starts one transfer. A transfer is a bus read from the source, then a bus write to the destination. A count register sets how many transfers the channel performs. When the count runs out, the channel switches itself off and can raise an interrupt.

The peripheral-side register is short. Its upper address bits are forced to all ones, so it always points into a peripheral window at the top of the address space. The memory-side address can step up or down after each transfer (sequential mode), or it can stay fixed (idle mode). Software programs the channel through a small register port while the channel is disabled. Software then sets the enable bit. After that, hardware activity follows the selected request line.

Top module: `sadma_channel`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `bus_req` is low.
- R2: Each accepted request performs exactly one bus read from the source address, then one bus write of that data to the destination address. Each completed write decrements the count by one. When the count reaches zero, the channel clears its enable bit (CTL bit 0) and sets its end flag (CTL bit 2).
- R3: The MODE register has the following fields: bit 0 = word size, bit 1 = peripheral-to-memory direction, bit 2 = decrement, bit 3 = repeat select, bits 7:4 = request source. In sequential mode (bit 3 = 0), the memory address changes after each transfer by 2 for words or 1 for bytes. It goes down when bit 2 = 1 and up when bit 2 = 0.
- R4: Idle mode is selected when MODE bit 3 and the interrupt enable (CTL bit 1) are both 1. In idle mode the memory address stays fixed across transfers.
- R5: When MODE bit 1 = 0, memory is the source and the peripheral is the destination; when bit 1 = 1, the reverse. The peripheral address on the bus is the IOADDR register value with all bits above it set to one.
- R6: In byte mode, only data bits 7:0 are moved, and the upper write-data bits are zero. In word mode, all 16 data bits are moved.
- R7: `bus_req`, `bus_we` and `bus_addr` hold steady from the start of a bus cycle until the cycle in which `bus_ack` is high.
- R8: Only a rising edge on `dreq[src]`, where src is MODE bits 7:4, starts a transfer. Edges on other lines have no effect.
- R9: While the enable bit is 1, writes to MADDR (select 0), IOADDR (1), COUNT (2) and MODE (3) are ignored. When the enable bit is 0, these writes take effect.
- R10: A request that arrives during a transfer is held and served after that transfer. At most one request is held; further edges during the same transfer are lost.
- R11: `irq` equals the end flag AND the interrupt enable. A CTL write (select 4) with bit 2 = 1 clears the end flag.
- R12: A request edge in the same cycle as the last transfer's write acknowledge starts no further transfer, and the count stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register select: 0 MADDR, 1 IOADDR, 2 COUNT, 3 MODE, 4 CTL |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Read data of the selected register, zero-extended |
| dreq | input | NREQ | Activation request lines |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | output | 1 | 1 = word access, 0 = byte access |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| bus_ack | input | 1 | Ends the current bus cycle |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The two functions that can land in the same clock edge are the count reaching zero on the final write acknowledge and the detection of a new request edge. The bench provokes this by having its bus responder raise the selected request line in exactly the cycle in which it acknowledges the last write. It then checks, through the register port and the bus, that the channel has disabled itself, the count reads zero rather than wrapping, and only one write happened. A second overlap (request edges arriving while a bus cycle is stalled) is judged by counting completed writes against the count read back.

// File: rtl/sadma_pkg.sv
package sadma_pkg;

   typedef enum logic [1:0] {
      XF_IDLE  = 2'd0,
      XF_READ  = 2'd1,
      XF_WRITE = 2'd2
   } xfer_state_e;

   typedef struct packed {
      logic [3:0] src;
      logic       rpt;
      logic       dec;
      logic       io_to_mem;
      logic       word;
   } mode_t;

   localparam logic [2:0] SEL_MADDR  = 3'd0;
   localparam logic [2:0] SEL_IOADDR = 3'd1;
   localparam logic [2:0] SEL_COUNT  = 3'd2;
   localparam logic [2:0] SEL_MODE   = 3'd3;
   localparam logic [2:0] SEL_CTL    = 3'd4;

endpackage

// File: rtl/sadma_regs.sv
module sadma_regs
   import sadma_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IOA_W  = 8,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        sel,
   input  logic              wr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   input  logic              step,
   output logic [ADDR_W-1:0] maddr,
   output logic [IOA_W-1:0]  ioaddr,
   output logic [CNT_W-1:0]  count,
   output mode_t             mode,
   output logic              en,
   output logic              ie,
   output logic              end_flag,
   output logic              idle_mode
);

   localparam int unsigned MODE_W = $bits(mode_t);
   localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(DATA_W / 8);
   localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

   logic [ADDR_W-1:0] step_amt;
   logic [ADDR_W-1:0] maddr_next;
   logic              cfg_open;

   assign idle_mode  = mode.rpt & ie;
   assign step_amt   = mode.word ? STEP_WORD : STEP_BYTE;
   assign maddr_next = mode.dec ? (maddr - step_amt) : (maddr + step_amt);
   assign cfg_open   = wr & ~en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         maddr    <= '0;
         ioaddr   <= '0;
         count    <= '0;
         mode     <= '0;
         en       <= 1'b0;
         ie       <= 1'b0;
         end_flag <= 1'b0;
      end else begin
         if (cfg_open) begin
            case (sel)
               SEL_MADDR:  maddr  <= wdata[ADDR_W-1:0];
               SEL_IOADDR: ioaddr <= wdata[IOA_W-1:0];
               SEL_COUNT:  count  <= wdata[CNT_W-1:0];
               SEL_MODE:   mode   <= mode_t'(wdata[MODE_W-1:0]);
               default: ;
            endcase
         end
         if (wr && sel == SEL_CTL) begin
            en <= wdata[0];
            ie <= wdata[1];
            if (wdata[2]) end_flag <= 1'b0;
         end
         if (step) begin
            count <= count - CNT_ONE;
            if (!idle_mode) maddr <= maddr_next;
            if (count == CNT_ONE) begin
               en       <= 1'b0;
               end_flag <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_MADDR:  rdata[ADDR_W-1:0] = maddr;
         SEL_IOADDR: rdata[IOA_W-1:0]  = ioaddr;
         SEL_COUNT:  rdata[CNT_W-1:0]  = count;
         SEL_MODE:   rdata[MODE_W-1:0] = mode;
         SEL_CTL:    rdata[2:0]        = {end_flag, ie, en};
         default:    rdata             = '0;
      endcase
   end

endmodule

// File: rtl/sadma_req.sv
module sadma_req #(
   parameter int unsigned NREQ     = 16,
   parameter bit          REQ_EDGE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] dreq,
   input  logic [3:0]      src,
   input  logic            en,
   input  logic            take,
   output logic            pend
);

   localparam int unsigned SRC_W = (NREQ > 1) ? $clog2(NREQ) : 1;

   logic sel_lvl;
   logic hit;

   always_comb begin
      sel_lvl = 1'b0;
      for (int i = 0; i < NREQ; i++) begin
         if (src == 4'(i)) sel_lvl = dreq[i];
      end
   end

   generate
      if (REQ_EDGE) begin : g_edge
         logic prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev <= 1'b0;
            else        prev <= sel_lvl;
         end
         assign hit = sel_lvl & ~prev;
      end else begin : g_level
         assign hit = sel_lvl;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pend <= 1'b0;
      else if (!en)  pend <= 1'b0;
      else if (hit)  pend <= 1'b1;
      else if (take) pend <= 1'b0;
   end

endmodule

// File: rtl/sadma_xfer.sv
module sadma_xfer
   import sadma_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IOA_W  = 8,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              word,
   input  logic              io_to_mem,
   input  logic [ADDR_W-1:0] maddr,
   input  logic [IOA_W-1:0]  ioaddr,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_word,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              take,
   output logic              step,
   output logic              busy
);

   localparam int unsigned HI_W = ADDR_W - IOA_W;

   xfer_state_e       state;
   logic [ADDR_W-1:0] io_full;
   logic [ADDR_W-1:0] src_q, dst_q;
   logic [DATA_W-1:0] data_q;
   logic              word_q;

   assign io_full = {{HI_W{1'b1}}, ioaddr};
   assign take    = (state == XF_IDLE) & go;
   assign step    = (state == XF_WRITE) & bus_ack;
   assign busy    = (state != XF_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= XF_IDLE;
         src_q  <= '0;
         dst_q  <= '0;
         data_q <= '0;
         word_q <= 1'b0;
      end else begin
         case (state)
            XF_IDLE: if (take) begin
               src_q  <= io_to_mem ? io_full : maddr;
               dst_q  <= io_to_mem ? maddr : io_full;
               word_q <= word;
               state  <= XF_READ;
            end
            XF_READ: if (bus_ack) begin
               data_q <= word_q ? bus_rdata : {{(DATA_W-8){1'b0}}, bus_rdata[7:0]};
               state  <= XF_WRITE;
            end
            XF_WRITE: if (bus_ack) state <= XF_IDLE;
            default: state <= XF_IDLE;
         endcase
      end
   end

   assign bus_req   = busy;
   assign bus_we    = (state == XF_WRITE);
   assign bus_word  = word_q;
   assign bus_addr  = (state == XF_WRITE) ? dst_q : src_q;
   assign bus_wdata = data_q;

endmodule

// File: rtl/sadma_channel.sv
module sadma_channel
   import sadma_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned IOA_W    = 8,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned REG_W    = 16,
   parameter int unsigned NREQ     = 16,
   parameter bit          REQ_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [NREQ-1:0]   dreq,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_word,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack,
   output logic              irq
);

   generate
      if (IOA_W >= ADDR_W) begin : g_chk_ioa
         $error("IOA_W must be narrower than ADDR_W");
      end
      if (REG_W < ADDR_W || REG_W < CNT_W || REG_W < 8) begin : g_chk_reg
         $error("REG_W too narrow for the register contents");
      end
      if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_chk_data
         $error("DATA_W must be a whole number of bytes, at least 16");
      end
      if (NREQ < 1 || NREQ > 16) begin : g_chk_nreq
         $error("NREQ must be between 1 and 16");
      end
   endgenerate

   logic [ADDR_W-1:0] maddr;
   logic [IOA_W-1:0]  ioaddr;
   logic [CNT_W-1:0]  count;
   mode_t             mode;
   logic              en, ie, end_flag, idle_mode;
   logic              pend, take, step, busy;

   sadma_regs #(
      .ADDR_W(ADDR_W), .IOA_W(IOA_W), .CNT_W(CNT_W),
      .DATA_W(DATA_W), .REG_W(REG_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .sel(reg_sel), .wr(reg_wr), .wdata(reg_wdata), .rdata(reg_rdata),
      .step(step),
      .maddr(maddr), .ioaddr(ioaddr), .count(count), .mode(mode),
      .en(en), .ie(ie), .end_flag(end_flag), .idle_mode(idle_mode)
   );

   sadma_req #(
      .NREQ(NREQ), .REQ_EDGE(REQ_EDGE)
   ) u_req (
      .clk(clk), .rst_n(rst_n),
      .dreq(dreq), .src(mode.src), .en(en), .take(take), .pend(pend)
   );

   sadma_xfer #(
      .ADDR_W(ADDR_W), .IOA_W(IOA_W), .DATA_W(DATA_W)
   ) u_xfer (
      .clk(clk), .rst_n(rst_n),
      .go(en & pend), .word(mode.word), .io_to_mem(mode.io_to_mem),
      .maddr(maddr), .ioaddr(ioaddr),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .take(take), .step(step), .busy(busy)
   );

   assign irq = end_flag & ie;

endmodule

// File: rtl/sadma_checker.sv
module sadma_checker #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic              bus_ack,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              irq,
   input logic              step,
   input logic              busy,
   input logic              en,
   input logic              end_flag,
   input logic              idle_mode,
   input logic              word,
   input logic              dec,
   input logic [ADDR_W-1:0] maddr,
   input logic [CNT_W-1:0]  count
);

   // R7: a stalled bus cycle keeps its request, address and direction
   a_r7_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));

   // R2: a completed read is followed by the write of the same transfer
   a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_we && bus_ack |=> bus_req && bus_we);

   // R2: the last write disables the channel and raises the end flag
   a_r2_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      step && count == CNT_W'(1) |=> !en && end_flag && count == '0);

   // R4: idle mode keeps the memory address
   a_r4_idle_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      step && idle_mode |=> $stable(maddr));

   // R3: sequential word increment steps by the word size in bytes
   a_r3_seq_word_up: assert property (@(posedge clk) disable iff (!rst_n)
      step && !idle_mode && word && !dec |=> maddr == $past(maddr) + ADDR_W'(DATA_W / 8));

   // R3: sequential byte decrement steps by one
   a_r3_seq_byte_down: assert property (@(posedge clk) disable iff (!rst_n)
      step && !idle_mode && !word && dec |=> maddr == $past(maddr) - ADDR_W'(1));

   // R9: no new bus cycle starts on a disabled idle channel
   a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en && !busy |=> !bus_req);

   // R11: the interrupt never shows without the end flag
   a_r11_irq_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> end_flag);

endmodule

bind sadma_channel sadma_checker #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .bus_req(bus_req), .bus_we(bus_we), .bus_ack(bus_ack), .bus_addr(bus_addr),
   .irq(irq), .step(step), .busy(busy), .en(en), .end_flag(end_flag),
   .idle_mode(idle_mode), .word(mode.word), .dec(mode.dec),
   .maddr(maddr), .count(count)
);

// File: tb/tb_sadma_channel.sv
`timescale 1ns/1ps
module tb_sadma_channel;

   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [15:0] dreq_tb = '0;
   logic [15:0] fire_vec = '0;
   logic        bus_req, bus_we, bus_word;
   logic [15:0] bus_addr, bus_wdata;
   logic [15:0] bus_rdata = '0;
   logic        bus_ack = 1'b0;
   logic        irq;

   logic [15:0] mem [0:255];
   int          n_writes = 0;
   logic [15:0] last_wa = '0;
   logic        fire_last = 1'b0;
   int          checks = 0;
   int          errors = 0;

   always #10 clk = ~clk;

   sadma_channel dut (
      .clk(clk), .rst_n(rst_n),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .dreq(dreq_tb | fire_vec),
      .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq(irq)
   );

   // bus responder: acknowledges after LAT stalled cycles
   initial begin
      int lat = 0;
      forever begin
         @(negedge clk);
         fire_vec = '0;
         if (bus_ack) begin
            bus_ack = 1'b0;
         end else if (bus_req) begin
            if (lat < LAT) begin
               lat++;
            end else begin
               lat = 0;
               bus_ack = 1'b1;
               if (bus_we) begin
                  mem[bus_addr[7:0]] = bus_wdata;
                  last_wa = bus_addr;
                  n_writes++;
                  if (fire_last) fire_vec = 16'h0004;
               end else begin
                  bus_rdata = mem[bus_addr[7:0]];
               end
            end
         end
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] s, input logic [15:0] d);
      @(negedge clk);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] s, output logic [15:0] d);
      @(negedge clk);
      reg_sel = s;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input int line);
      @(negedge clk);
      dreq_tb[line] = 1'b1;
      @(negedge clk);
      dreq_tb[line] = 1'b0;
   endtask

   task automatic settle();
      repeat (30) @(negedge clk);
   endtask

   task automatic setup(input logic [15:0] ma, input logic [15:0] ia,
                        input logic [15:0] cnt, input logic [15:0] md, input logic [15:0] ctl);
      wreg(3'd0, ma); wreg(3'd1, ia); wreg(3'd2, cnt); wreg(3'd3, md); wreg(3'd4, ctl);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      for (int s = 0; s < 5; s++) begin
         rreg(3'(s), v);
         chk("R1 reg reset", v, 16'h0000);
      end
      chk("R1 irq reset", {15'd0, irq}, 16'd0);
      chk("R1 bus_req reset", {15'd0, bus_req}, 16'd0);
   endtask

   task automatic t_seq_word();
      logic [15:0] v;
      int w0;
      mem[8'h10] = 16'hA1A1; mem[8'h12] = 16'hB2B2; mem[8'h14] = 16'hC3C3;
      setup(16'h0010, 16'h0080, 16'd3, 16'h0021, 16'h0003);
      w0 = n_writes;
      pulse(2);
      @(negedge clk);
      chk("R7 read cycle req", {15'd0, bus_req}, 16'd1);
      chk("R5 read from memory", bus_addr, 16'h0010);
      @(negedge clk);
      chk("R7 stalled addr held", bus_addr, 16'h0010);
      chk("R7 stalled still read", {15'd0, bus_we}, 16'd0);
      settle();
      chk("R2 first word", mem[8'h80], 16'hA1A1);
      chk("R5 io full address", last_wa, 16'hFF80);
      pulse(2); settle();
      pulse(2); settle();
      chk("R2 last word", mem[8'h80], 16'hC3C3);
      chk("R2 write count", 16'(n_writes - w0), 16'd3);
      rreg(3'd0, v); chk("R3 word increment", v, 16'h0016);
      rreg(3'd2, v); chk("R2 count zero", v, 16'd0);
      rreg(3'd4, v); chk("R2 end set, enable clear", v, 16'h0006);
      chk("R11 irq with ie", {15'd0, irq}, 16'd1);
      wreg(3'd4, 16'h0004);
      rreg(3'd4, v); chk("R11 end cleared", v, 16'h0000);
      chk("R11 irq dropped", {15'd0, irq}, 16'd0);
   endtask

   task automatic t_seq_byte_dec();
      logic [15:0] v;
      mem[8'h90] = 16'hBEEF; mem[8'h41] = 16'hFFFF; mem[8'h40] = 16'hFFFF;
      setup(16'h0041, 16'h0090, 16'd2, 16'h0026, 16'h0001);
      pulse(2); settle();
      pulse(2); settle();
      chk("R6 byte upper zero", mem[8'h41], 16'h00EF);
      chk("R6 second byte", mem[8'h40], 16'h00EF);
      rreg(3'd0, v); chk("R3 byte decrement", v, 16'h003F);
      rreg(3'd4, v); chk("R11 end only", v, 16'h0004);
      chk("R11 irq masked", {15'd0, irq}, 16'd0);
      wreg(3'd4, 16'h0004);
   endtask

   task automatic t_idle();
      logic [15:0] v;
      mem[8'h20] = 16'h5A5A; mem[8'hA0] = 16'h0000;
      setup(16'h0020, 16'h00A0, 16'd2, 16'h0029, 16'h0003);
      pulse(2); settle();
      rreg(3'd0, v); chk("R4 idle addr after one", v, 16'h0020);
      pulse(2); settle();
      rreg(3'd0, v); chk("R4 idle addr fixed", v, 16'h0020);
      chk("R4 idle data", mem[8'hA0], 16'h5A5A);
      chk("R11 idle irq", {15'd0, irq}, 16'd1);
      wreg(3'd4, 16'h0004);
   endtask

   task automatic t_select_and_lock();
      logic [15:0] v;
      setup(16'h0030, 16'h00B0, 16'd4, 16'h0051, 16'h0001);
      pulse(3); settle();
      rreg(3'd2, v); chk("R8 other line ignored", v, 16'd4);
      pulse(5); settle();
      rreg(3'd2, v); chk("R8 selected line", v, 16'd3);
      wreg(3'd0, 16'h0077);
      rreg(3'd0, v); chk("R9 write ignored while enabled", v, 16'h0032);
      wreg(3'd4, 16'h0000);
      wreg(3'd0, 16'h0077);
      rreg(3'd0, v); chk("R9 write taken when disabled", v, 16'h0077);
   endtask

   task automatic t_pending();
      logic [15:0] v;
      int w0;
      setup(16'h0050, 16'h00C0, 16'd10, 16'h0021, 16'h0001);
      w0 = n_writes;
      pulse(2); pulse(2); pulse(2);
      settle(); settle();
      rreg(3'd2, v); chk("R10 one held request", v, 16'd8);
      chk("R10 write count", 16'(n_writes - w0), 16'd2);
      wreg(3'd4, 16'h0000);
   endtask

   task automatic t_coincide();
      logic [15:0] v;
      int w0;
      setup(16'h0060, 16'h00D0, 16'd1, 16'h0021, 16'h0001);
      w0 = n_writes;
      fire_last = 1'b1;
      pulse(2);
      settle();
      fire_last = 1'b0;
      settle();
      rreg(3'd2, v); chk("R12 count stays zero", v, 16'd0);
      rreg(3'd4, v); chk("R12 disabled with end", v, 16'h0004);
      chk("R12 single write", 16'(n_writes - w0), 16'd1);
      chk("R12 bus idle", {15'd0, bus_req}, 16'd0);
      wreg(3'd4, 16'h0004);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_seq_word();
      t_seq_byte_dec();
      t_idle();
      t_select_and_lock();
      t_pending();
      t_coincide();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule